// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller gathers fourteen interrupt lines and chooses one to present to the core. Lines 0 to 11 come from general sources. Line 12 is reserved for the timer. Line 13 carries the performance-counter request. Every line has a mask bit and a programmable 4-bit priority. The line states are captured in a pending register on every clock. The choice of winner and the vector offset are then formed combinationally from the pending, mask and configuration registers.

A control register selects the mode. In legacy mode there is no priority ordering and every request shares vector offset zero. In vectored mode the line with the numerically lowest priority wins. Ties go to the higher line number. The winner's vector offset is its line number shifted by a programmable spacing. A timer-routing bit decides whether the timer raises its own line 12 or is merged into line 7. A global enable bit in the control register gates all requests.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all configuration registers are zero and irq_valid, irq_id, irq_prio and vec_offset are all 0.
- R2: irq_valid is 1 only when the global enable (control bit 5) is 1 and at least one pending line has its mask bit set. While irq_valid is 0, irq_id, irq_prio and vec_offset are 0.
- R3: In vectored mode (control bit 4 = 1), irq_id is the active line with the lowest priority value (0 is most urgent). Among lines with equal priority, the highest line number wins. irq_prio reports that line's priority.
- R4: In vectored mode, vec_offset equals irq_id shifted left by (min(spacing, 4) + 5). Spacing is control bits 2:0, so values 5 to 7 behave as 4.
- R5: In legacy mode (control bit 4 = 0), irq_id is the highest-numbered active line, irq_prio is 0 and vec_offset is 0.
- R6: With timer-exclusive (control bit 3) set to 1, the timer request pends line 12. With it at 0, the timer is ORed into line 7 and line 12 never pends.
- R7: perf_req pends line 13, and src_irq[i] pends line i for i from 0 to 11.
- R8: Mask bits for lines 0 to 7 are register 1 bits 7:0. Mask bits for lines 8 to 13 are control bits 13:8. Control bits 15:14 are reserved and unmask nothing.
- R9: Request inputs are registered. A change on src_irq, timer_req or perf_req shows on the outputs after the next rising clock edge and not before it.
- R10: Register map on wr_addr: 0 is control, 1 is the low mask, 2 holds the priorities of lines 0 to 7, and 3 holds the priorities of lines 8 to 13. Line i uses nibble bits 4k+3:4k of its register, with k = i for register 2 and k = i-8 for register 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Register write data |
| src_irq | input | 12 | General interrupt requests, lines 0 to 11 |
| timer_req | input | 1 | Timer interrupt request |
| perf_req | input | 1 | Performance-counter interrupt request |
| irq_valid | output | 1 | An enabled, unmasked request is pending |
| irq_id | output | 4 | Winning line number |
| irq_prio | output | 4 | Priority of the winning line |
| vec_offset | output | 13 | Vector offset of the winning line |

## Verification
The hardest situations to reach are the ones where the priority order disagrees with the line-number order: a masked line that would otherwise win, ties among several lines, and the timer folded into line 7. The stimulus table sets up all three. One vector gives a masked line a better priority than the unmasked winner. Another sets every priority to zero so that the higher-index rule alone decides. A third clears timer-exclusive while only the timer is requesting. Directed steps then confirm that the reserved mask bits do nothing and that a request change appears one edge late.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int NUM_LINES      = 14;
    localparam int NUM_GEN        = 12;
    localparam int PRIO_W         = 4;
    localparam int ID_W           = 4;
    localparam int SPC_W          = 3;
    localparam int SPC_MAX        = 4;
    localparam int VEC_BASE_SHIFT = 5;
    localparam int VEC_W          = ID_W + SPC_MAX + VEC_BASE_SHIFT;
    localparam int SHARED_LINE    = 7;
    localparam int TIMER_LINE     = 12;
    localparam int PERF_LINE      = 13;
    localparam int LO_LINES       = 8;

    typedef enum logic {
        MODE_LEGACY   = 1'b0,
        MODE_VECTORED = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic [SPC_W-1:0] spacing;
        logic             timer_excl;
        irq_mode_e        mode;
        logic             gie;
    } irq_cfg_t;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    output irq_cfg_t                    cfg,
    output logic [NUM_LINES-1:0]        mask,
    output logic [NUM_LINES*PRIO_W-1:0] prio_flat
);
    localparam int HI_LINES = NUM_LINES - LO_LINES;

    logic [LO_LINES-1:0] mask_lo_q;
    logic [HI_LINES-1:0] mask_hi_q;
    irq_cfg_t            cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            mask_lo_q <= '0;
            mask_hi_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                2'd0: begin
                    cfg_q.spacing    <= wr_data[SPC_W-1:0];
                    cfg_q.timer_excl <= wr_data[3];
                    cfg_q.mode       <= irq_mode_e'(wr_data[4]);
                    cfg_q.gie        <= wr_data[5];
                    mask_hi_q        <= wr_data[8 +: HI_LINES];
                end
                2'd1:    mask_lo_q <= wr_data[LO_LINES-1:0];
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
        localparam logic [1:0] ADDR = (i < LO_LINES) ? 2'd2 : 2'd3;
        localparam int         K    = (i < LO_LINES) ? i : i - LO_LINES;
        logic [PRIO_W-1:0] prio_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_q <= '0;
            else if (wr_en && wr_addr == ADDR)
                prio_q <= wr_data[K*PRIO_W +: PRIO_W];
        end
        assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;
    end

    assign cfg  = cfg_q;
    assign mask = {mask_hi_q, mask_lo_q};
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend
    import prio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GEN-1:0]   src_irq,
    input  logic                 timer_req,
    input  logic                 perf_req,
    input  logic                 timer_excl,
    output logic [NUM_LINES-1:0] pend
);
    logic [NUM_LINES-1:0] pend_d;
    logic [NUM_LINES-1:0] pend_q;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_route
        if (i == TIMER_LINE) begin : g_tmr
            assign pend_d[i] = timer_req & timer_excl;
        end else if (i == PERF_LINE) begin : g_perf
            assign pend_d[i] = perf_req;
        end else if (i == SHARED_LINE) begin : g_shared
            assign pend_d[i] = src_irq[i] | (timer_req & ~timer_excl);
        end else begin : g_plain
            assign pend_d[i] = src_irq[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    AST_LINE12_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_excl |=> !pend_q[TIMER_LINE]); // R6
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
    import prio_irq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        active,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    input  irq_mode_e                   mode,
    input  logic [SPC_W-1:0]            spacing,
    output logic                        irq_valid,
    output logic [ID_W-1:0]             irq_id,
    output logic [PRIO_W-1:0]           irq_prio,
    output logic [VEC_W-1:0]            vec_offset
);
    localparam int SH_W = $clog2(SPC_MAX + VEC_BASE_SHIFT + 1);

    logic              found;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_prio;
    logic [SH_W-1:0]   shift;

    always_comb begin
        found     = 1'b0;
        best_id   = '0;
        best_prio = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (active[i]) begin
                unique case (mode)
                    MODE_VECTORED: begin
                        if (!found || prio_flat[i*PRIO_W +: PRIO_W] <= best_prio) begin
                            best_id   = ID_W'(i);
                            best_prio = prio_flat[i*PRIO_W +: PRIO_W];
                        end
                    end
                    MODE_LEGACY: begin
                        best_id   = ID_W'(i);
                        best_prio = '0;
                    end
                endcase
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (spacing > SPC_W'(SPC_MAX))
            shift = SH_W'(SPC_MAX + VEC_BASE_SHIFT);
        else
            shift = SH_W'(spacing) + SH_W'(VEC_BASE_SHIFT);
    end

    always_comb begin
        irq_valid  = found;
        irq_id     = best_id;
        irq_prio   = best_prio;
        vec_offset = '0;
        if (found && mode == MODE_VECTORED)
            vec_offset = VEC_W'(best_id) << shift;
    end

    AST_WIN_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> active[irq_id]); // R2
    AST_LEGACY_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LEGACY) |-> (vec_offset == '0 && irq_prio == '0)); // R5
    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && mode == MODE_VECTORED) |-> (vec_offset[VEC_BASE_SHIFT-1:0] == '0)); // R4

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_chk
        AST_WIN_BEST: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_valid && mode == MODE_VECTORED && active[j]) |->
            ((prio_flat[j*PRIO_W +: PRIO_W] > irq_prio) ||
             (prio_flat[j*PRIO_W +: PRIO_W] == irq_prio && ID_W'(j) <= irq_id))); // R3
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [NUM_GEN-1:0]          src_irq,
    input  logic                        timer_req,
    input  logic                        perf_req,
    output logic                        irq_valid,
    output logic [ID_W-1:0]             irq_id,
    output logic [PRIO_W-1:0]           irq_prio,
    output logic [VEC_W-1:0]            vec_offset
);
    irq_cfg_t                    cfg;
    logic [NUM_LINES-1:0]        mask;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic [NUM_LINES-1:0]        pend;
    logic [NUM_LINES-1:0]        active;

    prio_irq_regs #(.DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .mask      (mask),
        .prio_flat (prio_flat)
    );

    prio_irq_pend pend_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_irq    (src_irq),
        .timer_req  (timer_req),
        .perf_req   (perf_req),
        .timer_excl (cfg.timer_excl),
        .pend       (pend)
    );

    assign active = pend & mask & {NUM_LINES{cfg.gie}};

    prio_irq_arb arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .prio_flat  (prio_flat),
        .mode       (cfg.mode),
        .spacing    (cfg.spacing),
        .irq_valid  (irq_valid),
        .irq_id     (irq_id),
        .irq_prio   (irq_prio),
        .vec_offset (vec_offset)
    );

    AST_GATED_BY_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.gie |-> !irq_valid); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_id == '0 && vec_offset == '0)); // R2
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] src_irq = '0;
    logic        timer_req = 1'b0;
    logic        perf_req = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_id;
    logic [3:0]  irq_prio;
    logic [12:0] vec_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_irq(src_irq), .timer_req(timer_req),
        .perf_req(perf_req), .irq_valid(irq_valid), .irq_id(irq_id),
        .irq_prio(irq_prio), .vec_offset(vec_offset)
    );

    typedef struct packed {
        logic [11:0] src;
        logic        tmr;
        logic        perf;
        logic [15:0] ctrl;
        logic [7:0]  mlo;
        logic [31:0] plo;
        logic [31:0] phi;
        logic        ev;
        logic [3:0]  eid;
        logic [3:0]  epri;
        logic [12:0] evec;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TABLE [NV] = '{
        '{12'h0A0, 1'b0, 1'b0, 16'h3F38, 8'hFF, 32'h76543210, 32'h00DCBA98, 1'b1, 4'd5,  4'd5, 13'd160},  // R3 R4 lowest prio wins
        '{12'h802, 1'b0, 1'b1, 16'h3F38, 8'hFF, 32'h76543210, 32'h00DCBA98, 1'b1, 4'd1,  4'd1, 13'd32},   // R3 R7
        '{12'h00F, 1'b1, 1'b0, 16'h3F3A, 8'hFF, 32'h0,        32'h0,        1'b1, 4'd12, 4'd0, 13'd1536}, // R3 tie, R6 line12
        '{12'h040, 1'b0, 1'b0, 16'h3F3F, 8'hFF, 32'h0,        32'h0,        1'b1, 4'd6,  4'd0, 13'd3072}, // R4 clamp
        '{12'h204, 1'b0, 1'b0, 16'h3F28, 8'hFF, 32'h76543210, 32'h00DCBA98, 1'b1, 4'd9,  4'd0, 13'd0},    // R5 legacy
        '{12'h000, 1'b1, 1'b0, 16'h3F30, 8'hFF, 32'h76543210, 32'h00DCBA98, 1'b1, 4'd7,  4'd7, 13'd224},  // R6 timer on line 7
        '{12'h010, 1'b0, 1'b0, 16'h3F38, 8'h00, 32'h76543210, 32'h00DCBA98, 1'b0, 4'd0,  4'd0, 13'd0},    // R8 masked
        '{12'hFFF, 1'b1, 1'b1, 16'h3F18, 8'hFF, 32'h76543210, 32'h00DCBA98, 1'b0, 4'd0,  4'd0, 13'd0},    // R2 gie off
        '{12'h028, 1'b0, 1'b0, 16'h3F38, 8'h08, 32'h76044215, 32'h00DCBA98, 1'b1, 4'd3,  4'd4, 13'd96}    // R8 R10 mask overrides prio
    };

    task automatic chk(input string tag, input logic ev, input logic [3:0] eid,
                       input logic [3:0] epri, input logic [12:0] evec);
        checks++;
        if (irq_valid !== ev || irq_id !== eid || irq_prio !== epri || vec_offset !== evec) begin
            errors++;
            $display("FAIL %s: got v=%0b id=%0d pri=%0d vec=%0d, expected v=%0b id=%0d pri=%0d vec=%0d",
                     tag, irq_valid, irq_id, irq_prio, vec_offset, ev, eid, epri, evec);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic [15:0] c, input logic [7:0] ml,
                         input logic [31:0] pl, input logic [31:0] ph);
        wr(2'd0, {16'h0, c});
        wr(2'd1, {24'h0, ml});
        wr(2'd2, pl);
        wr(2'd3, ph);
    endtask

    task automatic drive(input logic [11:0] s, input logic t, input logic p);
        src_irq = s; timer_req = t; perf_req = p;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 1'b0, 4'd0, 4'd0, 13'd0);
        rst_n = 1'b1;
        drive(12'hFFF, 1'b1, 1'b1);
        chk("R1 cleared regs keep outputs idle", 1'b0, 4'd0, 4'd0, 13'd0);

        for (int k = 0; k < NV; k++) begin
            drive(12'h0, 1'b0, 1'b0);
            setup(TABLE[k].ctrl, TABLE[k].mlo, TABLE[k].plo, TABLE[k].phi);
            drive(TABLE[k].src, TABLE[k].tmr, TABLE[k].perf);
            chk($sformatf("table vector %0d", k), TABLE[k].ev, TABLE[k].eid,
                TABLE[k].epri, TABLE[k].evec);
        end

        // R8: reserved control bits 15:14 unmask nothing
        drive(12'h0, 1'b0, 1'b0);
        setup(16'hC038, 8'h00, 32'h0, 32'h0);
        drive(12'h0, 1'b1, 1'b1);
        chk("R8 reserved mask bits", 1'b0, 4'd0, 4'd0, 13'd0);

        // R6: timer-exclusive clear, only line 12 unmasked
        drive(12'h0, 1'b0, 1'b0);
        setup(16'h1030, 8'h00, 32'h0, 32'h0);
        drive(12'h0, 1'b1, 1'b0);
        chk("R6 line 12 silent when shared", 1'b0, 4'd0, 4'd0, 13'd0);

        // R9: one-edge latency
        drive(12'h0, 1'b0, 1'b0);
        setup(16'h3F38, 8'hFF, 32'h76543210, 32'h00DCBA98);
        drive(12'h020, 1'b0, 1'b0);
        chk("R9 settled", 1'b1, 4'd5, 4'd5, 13'd160);
        src_irq = 12'h002;
        #1;
        chk("R9 before edge", 1'b1, 4'd5, 4'd5, 13'd160);
        @(negedge clk);
        chk("R9 after edge", 1'b1, 4'd1, 4'd1, 13'd32);

        // R3: tie at line 13 vs line 8 with equal priorities
        drive(12'h0, 1'b0, 1'b0);
        setup(16'h3F38, 8'hFF, 32'h0, 32'h00300003);
        drive(12'h100, 1'b0, 1'b1);
        chk("R3 tie high index", 1'b1, 4'd13, 4'd3, 13'd416);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule